// File: doc/BRIEF.md
# Tournament Predictor Chooser

This block picks the final branch direction from two component predictors, one driven by global history and one by per-branch local history. It keeps a table of small saturating selector counters, addressed by bits of the branch PC. Each counter learns which of the two components has been more reliable for the branches that map to its entry. The upper half of the counter range chooses the global prediction and the lower half chooses the local one, so different branches can favour different components.

On the lookup side, the PC and both component predictions arrive in the same cycle. The final prediction leaves combinationally from a table read and a two-way mux. On the update side, the resolved outcome arrives with the two component predictions that were made for that branch. The counter moves one step toward whichever component alone was right. A registered flag reports which component was chosen for the most recent valid lookup, for statistics gathering. The component predictors and target prediction sit outside this block.

Top module: `tp_chooser`

## Requirements
- R1: An asserted reset (rst_n low) sets every selector counter to the weak-local value (3 for 3-bit counters) and clears sel_global_q, so after reset every PC takes the local prediction.
- R2: pred_taken equals lk_glob_pred when the selector counter at the lookup index is in the upper half of its range (4 to 7 for 3-bit counters), and equals lk_loc_pred when it is in the lower half (0 to 3).
- R3: An update in which only the global component matched up_taken raises the indexed counter by one, saturating at the maximum (7).
- R4: An update in which only the local component matched up_taken lowers the indexed counter by one, saturating at 0.
- R5: An update in which both components matched up_taken, or neither did, leaves the indexed counter unchanged.
- R6: The table index is PC bits [ALIGN_W+IDX_W-1:ALIGN_W] (bits 11:2 by default). An update changes only the entry at that index, and PCs that differ only outside these bits share one entry.
- R7: An update takes effect at the clock edge that samples it. A lookup of the same entry in the same cycle sees the value from before the update, and a lookup in the next cycle sees the new value.
- R8: sel_global_q is registered. In the cycle after a lookup with lk_valid high, it is 1 if the global component was chosen and 0 if the local one was. It holds its value while lk_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_valid | input | 1 | Lookup qualifier for the chosen-component flag |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_glob_pred | input | 1 | Global component prediction for the lookup |
| lk_loc_pred | input | 1 | Local component prediction for the lookup |
| pred_taken | output | 1 | Final prediction, 1 = taken |
| sel_global_q | output | 1 | Registered: 1 when the last valid lookup chose the global component |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_glob_pred | input | 1 | Global prediction that was made for this branch |
| up_loc_pred | input | 1 | Local prediction that was made for this branch |

## Verification
The component predictions are driven in disagreement, so the output shows which component the selector picks. Agreeing inputs are used only to confirm the mux passes a common value. Four update patterns are applied to one entry while its neighbour and an aliasing PC are watched: global-only correct, local-only correct, both correct and both wrong. This separates a step in the right direction from a step in the wrong one and from an unintended write elsewhere. Long runs of one-sided updates push a counter against both ends of its range, where a wrap-around would flip the chosen component. Same-cycle lookup and update of one entry show whether the write is seen one cycle late, as required.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

endpackage

// File: rtl/tp_sel_cell.sv
module tp_sel_cell #(
  parameter int CNT_W   = 3,
  parameter int RST_VAL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] q
);

  logic [CNT_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CNT_W'(RST_VAL);
    else        q <= q_d;
  end

  // R6: an entry that is not written keeps its value
  a_r6_cell_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/tp_sel_table.sv
module tp_sel_table #(
  parameter int IDX_W   = 10,
  parameter int CNT_W   = 3,
  parameter int RST_VAL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CNT_W-1:0] rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CNT_W-1:0] rd_b
);

  localparam int DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] ctr_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    tp_sel_cell #(
      .CNT_W  (CNT_W),
      .RST_VAL(RST_VAL)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en && (wr_idx == IDX_W'(i))),
      .wr_val(wr_val),
      .q     (ctr_q[i])
    );
  end

  assign rd_a = ctr_q[rd_a_idx];
  assign rd_b = ctr_q[rd_b_idx];

endmodule

// File: rtl/tp_sel_next.sv
module tp_sel_next #(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             glob_ok,
  input  logic             loc_ok,
  output logic [CNT_W-1:0] nxt
);

  localparam logic [CNT_W-1:0] CTR_MAX = '1;
  localparam logic [CNT_W-1:0] CTR_MIN = '0;

  always_comb begin
    nxt = cur;
    if (glob_ok && !loc_ok) begin
      if (cur != CTR_MAX) nxt = cur + 1'b1;
    end else if (loc_ok && !glob_ok) begin
      if (cur != CTR_MIN) nxt = cur - 1'b1;
    end
  end

endmodule

// File: rtl/tp_chooser.sv
module tp_chooser
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 10,
  parameter int ALIGN_W = 2,
  parameter int CNT_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_glob_pred,
  input  logic            lk_loc_pred,
  output logic            pred_taken,
  output logic            sel_global_q,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_glob_pred,
  input  logic            up_loc_pred
);

  localparam int               RST_VAL = (1 << (CNT_W - 1)) - 1;
  localparam logic [CNT_W-1:0] CTR_MAX = '1;
  localparam logic [CNT_W-1:0] CTR_MIN = '0;

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  logic [CNT_W-1:0] lk_ctr;
  logic [CNT_W-1:0] up_ctr;
  logic [CNT_W-1:0] up_nxt;
  logic             glob_ok;
  logic             loc_ok;
  pick_e            lk_pick;
  logic             sel_global_d;
  logic             unused_pc_bits;

  assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
  assign up_idx = up_pc[ALIGN_W +: IDX_W];
  assign unused_pc_bits = ^{lk_pc, up_pc};

  assign glob_ok = (up_glob_pred == up_taken);
  assign loc_ok  = (up_loc_pred == up_taken);

  tp_sel_table #(
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .RST_VAL(RST_VAL)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (up_valid),
    .wr_idx  (up_idx),
    .wr_val  (up_nxt),
    .rd_a_idx(lk_idx),
    .rd_a    (lk_ctr),
    .rd_b_idx(up_idx),
    .rd_b    (up_ctr)
  );

  tp_sel_next #(
    .CNT_W(CNT_W)
  ) u_next (
    .cur    (up_ctr),
    .glob_ok(glob_ok),
    .loc_ok (loc_ok),
    .nxt    (up_nxt)
  );

  // Output mux driven by the selector MSB
  assign lk_pick    = pick_e'(lk_ctr[CNT_W-1]);
  assign pred_taken = (lk_pick == PICK_GLOBAL) ? lk_glob_pred : lk_loc_pred;

  always_comb begin
    sel_global_d = sel_global_q;
    if (lk_valid) sel_global_d = (lk_pick == PICK_GLOBAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_global_q <= 1'b0;
    else        sel_global_q <= sel_global_d;
  end

  // R8: registered flag agrees with the component that drove the output
  a_r8_choice_flag : assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (lk_glob_pred != lk_loc_pred)) |=>
      (sel_global_q == ($past(pred_taken) == $past(lk_glob_pred))));

  // R8: flag holds while no lookup is qualified
  a_r8_flag_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(sel_global_q));

  // R5: agreeing components leave the entry untouched
  a_r5_no_move : assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (glob_ok == loc_ok)) ##1 (up_idx == $past(up_idx)) |->
      (up_ctr == $past(up_ctr)));

  // R3: global-only correct steps up with saturation
  a_r3_step_up : assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && glob_ok && !loc_ok) ##1 (up_idx == $past(up_idx)) |->
      (up_ctr == (($past(up_ctr) == CTR_MAX) ? CTR_MAX
                                             : CNT_W'($past(up_ctr) + 1'b1))));

  // R4: local-only correct steps down with saturation
  a_r4_step_down : assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && loc_ok && !glob_ok) ##1 (up_idx == $past(up_idx)) |->
      (up_ctr == (($past(up_ctr) == CTR_MIN) ? CTR_MIN
                                             : CNT_W'($past(up_ctr) - 1'b1))));

endmodule

// File: tb/tp_chooser_bench.sv
module tp_chooser_bench;

  typedef struct packed {
    logic        upd;
    logic [31:0] upc;
    logic        ut;
    logic        ug;
    logic        ul;
    logic [31:0] lpc;
    logic        lg;
    logic        ll;
    logic        exp;
  } vec_t;

  localparam logic [31:0] PC_A  = 32'h0000_0014;
  localparam logic [31:0] PC_B  = 32'h0000_0018;
  localparam logic [31:0] PC_AL = 32'h0000_1014;
  localparam logic [31:0] PC_C  = 32'h0000_0024;
  localparam int NVEC = 13;

  // Each row: update fields, lookup fields, expected pred_taken in that cycle
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_A, 1'b1, 1'b0, 1'b0},  // R1 reset weak local
    '{1'b1, PC_A,  1'b1, 1'b1, 1'b0, PC_A, 1'b1, 1'b0, 1'b0},  // R7 old value same cycle
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_A, 1'b1, 1'b0, 1'b1},  // R3 3->4 global
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_B, 1'b1, 1'b0, 1'b0},  // R6 neighbour untouched
    '{1'b1, PC_A,  1'b0, 1'b1, 1'b1, PC_A, 1'b0, 1'b1, 1'b0},  // both wrong
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_A, 1'b0, 1'b1, 1'b0},  // R5 still global
    '{1'b1, PC_A,  1'b1, 1'b1, 1'b1, PC_A, 1'b1, 1'b0, 1'b1},  // both right
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_A, 1'b1, 1'b0, 1'b1},  // R5 still global
    '{1'b1, PC_A,  1'b1, 1'b0, 1'b1, PC_A, 1'b1, 1'b0, 1'b1},  // local only right
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_A, 1'b1, 1'b0, 1'b0},  // R4 4->3 local
    '{1'b1, PC_AL, 1'b1, 1'b1, 1'b0, PC_B, 1'b1, 1'b0, 1'b0},  // aliasing update
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_A, 1'b1, 1'b0, 1'b1},  // R6 alias shares entry
    '{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, PC_B, 1'b1, 1'b1, 1'b1}   // R2 agreeing inputs
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic        lk_glob_pred;
  logic        lk_loc_pred;
  logic        pred_taken;
  logic        sel_global_q;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_taken;
  logic        up_glob_pred;
  logic        up_loc_pred;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tp_chooser u_tp_chooser (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_pc       (lk_pc),
    .lk_glob_pred(lk_glob_pred),
    .lk_loc_pred (lk_loc_pred),
    .pred_taken  (pred_taken),
    .sel_global_q(sel_global_q),
    .up_valid    (up_valid),
    .up_pc       (up_pc),
    .up_taken    (up_taken),
    .up_glob_pred(up_glob_pred),
    .up_loc_pred (up_loc_pred)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge; outputs settle 1 ns later
  task automatic drive(input logic upd, input logic [31:0] upc, input logic ut,
                       input logic ug, input logic ul, input logic lv,
                       input logic [31:0] lpc, input logic lg, input logic ll);
    @(negedge clk);
    up_valid = upd; up_pc = upc; up_taken = ut;
    up_glob_pred = ug; up_loc_pred = ul;
    lk_valid = lv; lk_pc = lpc; lk_glob_pred = lg; lk_loc_pred = ll;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    check("R1 sel_global_q in reset", sel_global_q, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].upd, VEC[i].upc, VEC[i].ut, VEC[i].ug, VEC[i].ul,
            1'b1, VEC[i].lpc, VEC[i].lg, VEC[i].ll);
      check($sformatf("R2/R7 vector %0d pred_taken", i), pred_taken, VEC[i].exp);
    end

    // R3 saturation at the top: six global-only updates from 3 must stop at 7
    for (int k = 0; k < 6; k++) drive(1'b1, PC_C, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_C, 1'b0, 1'b1);
    check("R3 saturated at max picks global", pred_taken, 1'b0);
    drive(1'b1, PC_C, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_C, 1'b1, 1'b0);
    check("R3 one step down from max stays global", pred_taken, 1'b1);

    // R4 saturation at the bottom: seven local-only from 6, then four global-only
    for (int k = 0; k < 7; k++) drive(1'b1, PC_C, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_C, 1'b1, 1'b0);
    check("R4 floor picks local", pred_taken, 1'b0);
    for (int k = 0; k < 4; k++) drive(1'b1, PC_C, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_C, 1'b1, 1'b0);
    check("R4 floor held at 0, four steps reach global", pred_taken, 1'b1);

    // R8 chosen-component flag (entry A is at 4, entry B at 3)
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_A, 1'b1, 1'b0);
    idle();
    check("R8 flag after global pick", sel_global_q, 1'b1);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, PC_B, 1'b1, 1'b0);
    idle();
    check("R8 flag held without lk_valid", sel_global_q, 1'b1);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_B, 1'b1, 1'b0);
    idle();
    check("R8 flag after local pick", sel_global_q, 1'b0);

    // R1 reset mid-run returns entry A to weak local and clears the flag
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_A, 1'b1, 1'b0);
    idle();
    check("R8 flag set before reset", sel_global_q, 1'b1);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 flag cleared by reset", sel_global_q, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, PC_A, 1'b1, 1'b0);
    check("R1 entry back to local after reset", pred_taken, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule